// File: doc/BRIEF.md
# Video pixel path mode selector

This block is the pixel path in front of the three colour converters of a palette-based video output stage. On every pixel clock it samples a 24-bit pixel word and a set of controls. The controls are two mode pins, a four-bit overlay select, an active-low blank and an active-low sync. It then produces one 8-bit colour code per channel, together with the matching blank and sync flags. The pixel is looked up in a 256-entry by 24-bit palette, looked up in a 15-entry overlay table, or formatted straight from the pixel bits with no lookup. The choice follows the mode pins, two command-register bits and the overlay select.

The palette and overlay storage sit in a separate host-access block. This block only drives their read addresses and takes back the data one clock later. The palette has one address per colour column, so each channel can use a different index. A pixel read mask and a six-bit colour flag come from the command registers as static levels.

Top module: `vidPixelPath`

## Requirements
- R1: Colour outputs, `outBlankN` and `outSyncN` change three clock edges after the inputs are sampled: input register, palette read, output register. The mask is used at the second edge and `sixBitEn` at the third.
- R2: A nonzero `ovlSel` selects overlay entry `ovlSel` (red `ovlData[23:16]`, green `[15:8]`, blue `[7:0]`). It overrides every colour mode, ignores the pixel and mode inputs, and is not masked.
- R3: Mode code {modeSel, cmdMode} = 0000 is 24-bit palette mode. The red column is read at `pixRed & pixMask`, green at `pixGreen & pixMask` and blue at `pixBlue & pixMask`.
- R4: Code 0001 is 24-bit bypass. The outputs equal the red, green and blue pixel bytes, with no palette lookup and no mask.
- R5: Codes 0100, 0101 and 0110 are 8-bit pseudo-colour. The port byte (red, green or blue for cmdMode 00, 01, 10) is ANDed with the mask and used as the address for all three columns.
- R6: Codes 1000, 1001 and 1010 are 8-bit bypass on the same port byte P. Red is {P[7:5],00000}, green {P[4:2],00000} and blue {P[1:0],000000}, with no palette and no mask.
- R7: Code 1100 is 15-bit bypass. Red is {R[6:2],000}, green {R[1:0],G[7:5],000} and blue {G[4:0],000}. R[7] and the blue port are unused.
- R8: All other codes (0010, 0011, 0111, 1011, 1101, 1110, 1111) behave as 24-bit palette mode.
- R9: When the sampled `blankN` is 0, all three colour outputs are 0 and `outBlankN` is 0, whatever the pixel, mode and overlay inputs.
- R10: `outSyncN` is the sampled `syncN` delayed per R1. Sync never alters the colour outputs or `outBlankN`.
- R11: When `sixBitEn` is 1, bits [1:0] of every colour output are 0.
- R12: During and after reset, until new samples arrive, the colour outputs are 0, `outBlankN` is 0 and `outSyncN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixRed | input | 8 | Red pixel byte |
| pixGreen | input | 8 | Green pixel byte |
| pixBlue | input | 8 | Blue pixel byte |
| modeSel | input | 2 | Mode pins, high part of the mode code |
| cmdMode | input | 2 | Command-register mode bits, low part of the mode code |
| ovlSel | input | 4 | Overlay select, 0 means no overlay |
| blankN | input | 1 | Active-low blank |
| syncN | input | 1 | Active-low sync |
| pixMask | input | 8 | Pixel read mask for palette indices |
| sixBitEn | input | 1 | Six-bit colour mode |
| palAddrRed | output | 8 | Red palette column read address |
| palAddrGreen | output | 8 | Green palette column read address |
| palAddrBlue | output | 8 | Blue palette column read address |
| palRdData | input | 24 | Palette read data, one cycle after address, red high |
| ovlAddr | output | 4 | Overlay table read address |
| ovlData | input | 24 | Overlay read data, one cycle after address, red high |
| outRed | output | 8 | Red colour code |
| outGreen | output | 8 | Green colour code |
| outBlue | output | 8 | Blue colour code |
| outBlankN | output | 1 | Delayed blank flag |
| outSyncN | output | 1 | Delayed sync flag |

## Verification
Each mode is driven with pseudo-random pixel bytes on all three ports. The wrong port choice, a swapped field or a missing mask then shows up in the output. Two palette modes are run with a full mask and a partial mask, and the mask is changed mid-stream to pin down the cycle in which it is sampled. All sixteen mode codes are swept to separate the undefined codes from the real ones. Random overlay selects, blanks, syncs and six-bit phases mixed over all modes show priority and latency alignment, and that sync does not touch the colour.

// File: rtl/vidPixPkg.sv
package vidPixPkg;
  parameter int COLOR_W = 8;
  parameter int NUM_CH  = 3;
  parameter int OVL_W   = 4;
  localparam int PIX_W  = COLOR_W * NUM_CH;

  typedef enum logic [2:0] {
    FMT_PAL24  = 3'd0,
    FMT_BYP24  = 3'd1,
    FMT_PSEUDO = 3'd2,
    FMT_BYP8   = 3'd3,
    FMT_BYP15  = 3'd4
  } pixFmt_e;

  // Strobes passed from control to datapath for one pipeline stage
  typedef struct packed {
    pixFmt_e    fmt;
    logic [1:0] portSel;
    logic       ovlHit;
    logic       blankN;
    logic       syncN;
  } pixStrobe_t;

  localparam pixStrobe_t STROBE_RST = '{fmt: FMT_PAL24, portSel: 2'b00,
                                        ovlHit: 1'b0, blankN: 1'b0, syncN: 1'b1};
endpackage

// File: rtl/vidPixCtrl.sv
module vidPixCtrl
  import vidPixPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       cmdMode,
  input  logic [OVL_W-1:0] ovlSel,
  input  logic             blankN,
  input  logic             syncN,
  output logic [OVL_W-1:0] ovlIdx,
  output pixStrobe_t       stage1,
  output pixStrobe_t       stage2,
  input  logic             outBlankN,
  input  logic             outSyncN
);
  logic [1:0]       modeQ;
  logic [1:0]       cmdQ;
  logic [OVL_W-1:0] ovlQ;
  logic             blankQ;
  logic             syncQ;
  logic [1:0]       sinceRst;

  // Input register for all control pins, aligned with the pixel bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      cmdQ   <= '0;
      ovlQ   <= '0;
      blankQ <= 1'b0;
      syncQ  <= 1'b1;
    end else begin
      modeQ  <= modeSel;
      cmdQ   <= cmdMode;
      ovlQ   <= ovlSel;
      blankQ <= blankN;
      syncQ  <= syncN;
    end
  end

  // Mode decode; unlisted codes fall back to 24-bit palette
  always_comb begin
    stage1.fmt     = FMT_PAL24;
    stage1.portSel = cmdQ;
    stage1.ovlHit  = |ovlQ;
    stage1.blankN  = blankQ;
    stage1.syncN   = syncQ;
    unique case (modeQ)
      2'b00: if (cmdQ == 2'b01) stage1.fmt = FMT_BYP24;
      2'b01: if (cmdQ != 2'b11) stage1.fmt = FMT_PSEUDO;
      2'b10: if (cmdQ != 2'b11) stage1.fmt = FMT_BYP8;
      2'b11: if (cmdQ == 2'b00) stage1.fmt = FMT_BYP15;
      default: stage1.fmt = FMT_PAL24;
    endcase
  end

  assign ovlIdx = ovlQ;

  // Strobes follow the data through the palette read stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage2 <= STROBE_RST;
    else       stage2 <= stage1;
  end

  // Cycles since reset, used only to bound the latency checks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_BLANK_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outBlankN == $past(blankN, 3)));  // R1
  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outSyncN == $past(syncN, 3)));  // R10
  AST_OVL_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0) |-> (stage1.ovlHit == ($past(ovlSel) != '0)));  // R2
endmodule

// File: rtl/vidPixData.sv
module vidPixData
  import vidPixPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [COLOR_W-1:0] pixRed,
  input  logic [COLOR_W-1:0] pixGreen,
  input  logic [COLOR_W-1:0] pixBlue,
  input  logic [COLOR_W-1:0] pixMask,
  input  logic               sixBitEn,
  input  pixStrobe_t         stage1,
  input  pixStrobe_t         stage2,
  output logic [COLOR_W-1:0] palAddr [NUM_CH],
  input  logic [PIX_W-1:0]   palRdData,
  input  logic [PIX_W-1:0]   ovlData,
  output logic [COLOR_W-1:0] outChan [NUM_CH]
);
  localparam int LSB_DROP = 2;

  logic [COLOR_W-1:0] pixQ [NUM_CH];
  logic [COLOR_W-1:0] portByte;
  logic [PIX_W-1:0]   bypFmt;
  logic [PIX_W-1:0]   bypQ;
  logic               usePal1;
  logic               usePal2;
  logic [COLOR_W-1:0] lsbKeep;

  // Pixel input register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) pixQ[c] <= '0;
    end else begin
      pixQ[0] <= pixRed;
      pixQ[1] <= pixGreen;
      pixQ[2] <= pixBlue;
    end
  end

  // Port byte for the single-byte modes
  always_comb begin
    unique case (stage1.portSel)
      2'b00:   portByte = pixQ[0];
      2'b01:   portByte = pixQ[1];
      default: portByte = pixQ[2];
    endcase
  end

  assign usePal1 = (stage1.fmt == FMT_PAL24) || (stage1.fmt == FMT_PSEUDO);
  assign usePal2 = (stage2.fmt == FMT_PAL24) || (stage2.fmt == FMT_PSEUDO);

  // Masked palette addresses, one per colour column
  for (genvar c = 0; c < NUM_CH; c++) begin : gAddr
    always_comb begin
      if (stage1.fmt == FMT_PSEUDO)     palAddr[c] = portByte & pixMask;
      else if (stage1.fmt == FMT_PAL24) palAddr[c] = pixQ[c] & pixMask;
      else                              palAddr[c] = '0;
    end
    AST_MASK_APPLIED: assert property (@(posedge clk) disable iff (!rstN)
      usePal1 |-> ((palAddr[c] & ~pixMask) == '0));  // R3
  end

  // Bypass bit packing
  always_comb begin
    unique case (stage1.fmt)
      FMT_BYP24: bypFmt = {pixQ[0], pixQ[1], pixQ[2]};
      FMT_BYP8:  bypFmt = {portByte[7:5], 5'b0, portByte[4:2], 5'b0,
                           portByte[1:0], 6'b0};
      FMT_BYP15: bypFmt = {pixQ[0][6:2], 3'b0,
                           pixQ[0][1:0], pixQ[1][7:5], 3'b0,
                           pixQ[1][4:0], 3'b0};
      default:   bypFmt = '0;
    endcase
  end

  // Bypass word waits alongside the palette read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bypQ <= '0;
    else       bypQ <= bypFmt;
  end

  assign lsbKeep = sixBitEn ? {{(COLOR_W-LSB_DROP){1'b1}}, {LSB_DROP{1'b0}}}
                            : {COLOR_W{1'b1}};

  // Output register, priority: blank, overlay, palette, bypass
  for (genvar c = 0; c < NUM_CH; c++) begin : gOut
    localparam int HI = PIX_W - 1 - c * COLOR_W;
    logic [COLOR_W-1:0] pick;
    always_comb begin
      if (!stage2.blankN)    pick = '0;
      else if (stage2.ovlHit) pick = ovlData[HI -: COLOR_W];
      else if (usePal2)       pick = palRdData[HI -: COLOR_W];
      else                    pick = bypQ[HI -: COLOR_W];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outChan[c] <= '0;
      else       outChan[c] <= pick & lsbKeep;
    end
    AST_SIX_BIT_LSB: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(sixBitEn)) |-> (outChan[c][LSB_DROP-1:0] == '0));  // R11
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(stage2.blankN)) |-> (outChan[c] == '0));  // R9
  end
endmodule

// File: rtl/vidPixelPath.sv
module vidPixelPath
  import vidPixPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   pixRed,
  input  logic [7:0]   pixGreen,
  input  logic [7:0]   pixBlue,
  input  logic [1:0]   modeSel,
  input  logic [1:0]   cmdMode,
  input  logic [3:0]   ovlSel,
  input  logic         blankN,
  input  logic         syncN,
  input  logic [7:0]   pixMask,
  input  logic         sixBitEn,
  output logic [7:0]   palAddrRed,
  output logic [7:0]   palAddrGreen,
  output logic [7:0]   palAddrBlue,
  input  logic [23:0]  palRdData,
  output logic [3:0]   ovlAddr,
  input  logic [23:0]  ovlData,
  output logic [7:0]   outRed,
  output logic [7:0]   outGreen,
  output logic [7:0]   outBlue,
  output logic         outBlankN,
  output logic         outSyncN
);
  pixStrobe_t         stage1;
  pixStrobe_t         stage2;
  logic [COLOR_W-1:0] palAddr [NUM_CH];
  logic [COLOR_W-1:0] outChan [NUM_CH];
  logic               blankOutQ;
  logic               syncOutQ;

  vidPixCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .cmdMode   (cmdMode),
    .ovlSel    (ovlSel),
    .blankN    (blankN),
    .syncN     (syncN),
    .ovlIdx    (ovlAddr),
    .stage1    (stage1),
    .stage2    (stage2),
    .outBlankN (blankOutQ),
    .outSyncN  (syncOutQ)
  );

  vidPixData i_data (
    .clk       (clk),
    .rstN      (rstN),
    .pixRed    (pixRed),
    .pixGreen  (pixGreen),
    .pixBlue   (pixBlue),
    .pixMask   (pixMask),
    .sixBitEn  (sixBitEn),
    .stage1    (stage1),
    .stage2    (stage2),
    .palAddr   (palAddr),
    .palRdData (palRdData),
    .ovlData   (ovlData),
    .outChan   (outChan)
  );

  // Flag output register, matched to the colour output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankOutQ <= 1'b0;
      syncOutQ  <= 1'b1;
    end else begin
      blankOutQ <= stage2.blankN;
      syncOutQ  <= stage2.syncN;
    end
  end

  assign palAddrRed   = palAddr[0];
  assign palAddrGreen = palAddr[1];
  assign palAddrBlue  = palAddr[2];
  assign outRed       = outChan[0];
  assign outGreen     = outChan[1];
  assign outBlue      = outChan[2];
  assign outBlankN    = blankOutQ;
  assign outSyncN     = syncOutQ;
endmodule

// File: tb/test_vidPixelPath.sv
module test_vidPixelPath;
  typedef struct packed {
    logic [7:0] r, g, b;
    logic [1:0] s, cr;
    logic [3:0] ovl;
    logic       bn, sn;
    logic [7:0] mask;
    logic       six;
  } vec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] pixRed = 0, pixGreen = 0, pixBlue = 0, pixMask = 8'hFF;
  logic [1:0] modeSel = 0, cmdMode = 0;
  logic [3:0] ovlSel = 0;
  logic blankN = 1'b0, syncN = 1'b1, sixBitEn = 1'b0;
  logic [7:0] palAddrRed, palAddrGreen, palAddrBlue;
  logic [23:0] palRdData = 0, ovlData = 0;
  logic [3:0] ovlAddr;
  logic [7:0] outRed, outGreen, outBlue;
  logic outBlankN, outSyncN;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;
  vec_t h0, h1, h2;

  always #4 clk = ~clk;

  vidPixelPath i_vidPixelPath (
    .clk(clk), .rstN(rstN), .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue),
    .modeSel(modeSel), .cmdMode(cmdMode), .ovlSel(ovlSel), .blankN(blankN),
    .syncN(syncN), .pixMask(pixMask), .sixBitEn(sixBitEn),
    .palAddrRed(palAddrRed), .palAddrGreen(palAddrGreen), .palAddrBlue(palAddrBlue),
    .palRdData(palRdData), .ovlAddr(ovlAddr), .ovlData(ovlData),
    .outRed(outRed), .outGreen(outGreen), .outBlue(outBlue),
    .outBlankN(outBlankN), .outSyncN(outSyncN));

  // Storage contents held by the host-access side
  function automatic [7:0] palR(input [7:0] a); return a ^ 8'hA5; endfunction
  function automatic [7:0] palG(input [7:0] a); return a + 8'h37; endfunction
  function automatic [7:0] palB(input [7:0] a); return {a[3:0], a[7:4]} ^ 8'h0F; endfunction
  function automatic [23:0] ovlF(input [3:0] i);
    return {i * 8'd17, 8'hF0 ^ {4'h0, i}, {i, ~i}};
  endfunction

  // One-cycle synchronous read ports
  always @(posedge clk) begin
    palRdData <= {palR(palAddrRed), palG(palAddrGreen), palB(palAddrBlue)};
    ovlData   <= ovlF(ovlAddr);
  end

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  function automatic [23:0] palLook(input [7:0] ir, input [7:0] ig, input [7:0] ib);
    return {palR(ir), palG(ig), palB(ib)};
  endfunction

  // Reference colour for a pixel, with the mask and six-bit flag in effect at their stages
  function automatic [23:0] expColour(input vec_t v, input [7:0] m, input six);
    logic [23:0] c;
    logic [7:0] p;
    p = (v.cr == 2'b00) ? v.r : (v.cr == 2'b01) ? v.g : v.b;
    if (!v.bn) c = 24'h0;
    else if (v.ovl != 0) c = ovlF(v.ovl);
    else if (v.s == 2'b00 && v.cr == 2'b01) c = {v.r, v.g, v.b};
    else if (v.s == 2'b01 && v.cr != 2'b11) c = palLook(p & m, p & m, p & m);
    else if (v.s == 2'b10 && v.cr != 2'b11)
      c = {p[7:5], 5'b0, p[4:2], 5'b0, p[1:0], 6'b0};
    else if (v.s == 2'b11 && v.cr == 2'b00)
      c = {v.r[6:2], 3'b0, v.r[1:0], v.g[7:5], 3'b0, v.g[4:0], 3'b0};
    else c = palLook(v.r & m, v.g & m, v.b & m);
    if (six) c = c & 24'hFCFCFC;
    return c;
  endfunction

  function automatic string tagOf(input vec_t v, input six);
    if (!v.bn) return "R9";
    if (v.ovl != 0) return "R2";
    if (six) return "R11";
    if (v.s == 2'b00 && v.cr == 2'b00) return "R3";
    if (v.s == 2'b00 && v.cr == 2'b01) return "R4";
    if (v.s == 2'b01 && v.cr != 2'b11) return "R5";
    if (v.s == 2'b10 && v.cr != 2'b11) return "R6";
    if (v.s == 2'b11 && v.cr == 2'b00) return "R7";
    return "R8";
  endfunction

  task automatic checkNow(input string phase);
    logic [23:0] e;
    e = expColour(h2, h1.mask, h0.six);
    checks++;
    if ({outRed, outGreen, outBlue} !== e) begin
      fails++;
      $display("FAIL %s colour (%s): actual %h expected %h", tagOf(h2, h0.six), phase,
               {outRed, outGreen, outBlue}, e);
    end
    checks++;
    if (outBlankN !== h2.bn || outSyncN !== h2.sn) begin
      fails++;
      $display("FAIL R1/R10 flags (%s): actual blank %b sync %b expected blank %b sync %b",
               phase, outBlankN, outSyncN, h2.bn, h2.sn);
    end
  endtask

  task automatic step(input vec_t v, input string phase);
    @(negedge clk);
    checkNow(phase);
    pixRed = v.r; pixGreen = v.g; pixBlue = v.b;
    modeSel = v.s; cmdMode = v.cr; ovlSel = v.ovl;
    blankN = v.bn; syncN = v.sn; pixMask = v.mask; sixBitEn = v.six;
    h2 = h1; h1 = h0; h0 = v;
  endtask

  function automatic vec_t mkVec(input [1:0] s, input [1:0] cr, input [7:0] mask, input six);
    vec_t v;
    int unsigned x;
    x = rnd();
    v.r = x[7:0]; v.g = x[15:8]; v.b = x[23:16];
    v.s = s; v.cr = cr; v.ovl = 4'h0; v.bn = 1'b1; v.sn = 1'b1;
    v.mask = mask; v.six = six;
    return v;
  endfunction

  task automatic runMode(input int n, input [1:0] s, input [1:0] cr, input [7:0] mask,
                         input six, input string phase);
    for (int i = 0; i < n; i++) step(mkVec(s, cr, mask, six), phase);
  endtask

  initial begin
    vec_t idle;
    vec_t v;
    int unsigned x;
    idle = '0; idle.sn = 1'b1; idle.mask = 8'hFF;
    h0 = idle; h1 = idle; h2 = idle;
    // R12: reset state
    for (int i = 0; i < 4; i++) step(idle, "reset R12");
    @(negedge clk);
    checks++;
    if ({outRed, outGreen, outBlue} !== 24'h0 || outBlankN !== 1'b0 || outSyncN !== 1'b1) begin
      fails++;
      $display("FAIL R12 reset: actual %h %b %b expected 000000 0 1",
               {outRed, outGreen, outBlue}, outBlankN, outSyncN);
    end
    rstN = 1'b1;
    step(idle, "post reset R12");
    step(idle, "post reset R12");
    // R3 with full and partial mask, mask changed mid-stream (R1 stage timing)
    runMode(30, 2'b00, 2'b00, 8'hFF, 1'b0, "pal24 full mask");
    runMode(30, 2'b00, 2'b00, 8'h3C, 1'b0, "pal24 mask 3C");
    for (int i = 0; i < 20; i++) step(mkVec(2'b00, 2'b00, (i % 2) ? 8'hF0 : 8'h0F, 1'b0), "mask toggle");
    // R4
    runMode(20, 2'b00, 2'b01, 8'h00, 1'b0, "bypass24");
    // R5 and R6 over each port
    for (int p = 0; p < 3; p++) begin
      runMode(15, 2'b01, p[1:0], 8'hFF, 1'b0, "pseudo");
      runMode(15, 2'b01, p[1:0], 8'h5A, 1'b0, "pseudo masked");
      runMode(15, 2'b10, p[1:0], 8'h00, 1'b0, "bypass8");
    end
    // R7
    runMode(25, 2'b11, 2'b00, 8'h00, 1'b0, "bypass15");
    // R8: sweep all codes, undefined ones map to palette mode
    for (int code = 0; code < 16; code++)
      runMode(4, code[3:2], code[1:0], 8'h77, 1'b0, "code sweep");
    // R2: overlay mixed into all modes
    for (int i = 0; i < 60; i++) begin
      x = rnd();
      v = mkVec(x[1:0], x[3:2], 8'hC3, 1'b0);
      v.ovl = (x[4]) ? x[8:5] : 4'h0;
      step(v, "overlay mix");
    end
    // R9 and R10: blank and sync random over overlay and modes
    for (int i = 0; i < 60; i++) begin
      x = rnd();
      v = mkVec(x[1:0], x[3:2], 8'hFF, 1'b0);
      v.ovl = x[7:4];
      v.bn = x[9] | x[10];
      v.sn = x[11];
      step(v, "blank sync mix");
    end
    // R11: six-bit flag toggled, with everything else random
    for (int i = 0; i < 80; i++) begin
      x = rnd();
      v = mkVec(x[1:0], x[3:2], x[15:8], x[16] | x[17]);
      v.ovl = x[18] ? x[22:19] : 4'h0;
      v.bn = x[23] | x[24] | x[25];
      v.sn = x[26];
      step(v, "six bit mix");
    end
    for (int i = 0; i < 4; i++) step(idle, "flush");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule